// File: doc/BRIEF.md
# Event Interrupt Status and Masking Unit

This unit collects single-cycle event pulses into a sticky 32-bit raw status word, filters it through a software-written mask and produces one level-sensitive interrupt line. The line is gated by an enable bit kept in a separate control word. Software sees the status word in two forms, raw and masked, and clears bits by writing ones to either form.

Two status bits belong to card detection. An insertion and a removal each set their own bit and clear the other one. They also drive a card-present flag in a read-only status word. All registers sit behind a simple single-cycle register port. Reads are combinational on the address. Writes take effect at the next clock edge.

Register offsets (byte addresses): control 0x00, mask 0x04, masked view 0x08, raw view 0x0C, card status 0x10.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the control, mask, raw, masked and card status reads all return 0 and `irq_o` is low.
- R2: A pulse on `evt_set_i[i]` (i from 0 to 29) sets raw bit i at the next clock edge. The bit stays set until software clears it.
- R3: A read at 0x08 returns raw AND mask. A read at 0x0C returns the full raw word.
- R4: A write at 0x08 or at 0x0C clears every raw bit that is 1 in the write data. All other raw bits are left unchanged.
- R5: If a set source and a write-one-to-clear hit the same raw bit in the same cycle, the bit ends up set.
- R6: A card insertion sets raw bit 30 (0x4000_0000), clears raw bit 31 and sets the card-present flag. The flag is bit 8 (0x100) of the word at 0x10. Clearing raw bit 30 does not change the flag.
- R7: A card removal sets raw bit 31 (0x8000_0000), clears raw bit 30 and clears the card-present flag. If insertion and removal arrive in the same cycle, the removal wins.
- R8: A write to the control word at 0x00 reads back with bits 2..0 forced to 0. All other bits read back as written.
- R9: `irq_o` is registered. One cycle after the state changes, it equals control bit 4 AND (raw AND mask) being non-zero.
- R10: The mask at 0x04 reads back as written. Writes to 0x10 and to unmapped offsets change nothing, and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set_i | input | 30 | Set pulses for raw bits 29..0 |
| card_insert_i | input | 1 | Card insertion pulse |
| card_remove_i | input | 1 | Card removal pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, the enable at bit 4, three self-clearing control bits and the present flag at bit 8. With this build the two card bits fall in the top two bit positions. Each card bit can therefore be checked against its neighbour and against the generic event bits in the same word. A scoreboard checks the one-cycle interrupt lag on every transition of the enable, the mask and the status. It also covers same-cycle collisions between clears, generic events and card events.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register byte offsets
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_MASK   = 'h04;
    localparam int OFS_MASKED = 'h08;
    localparam int OFS_RAW    = 'h0C;
    localparam int OFS_CARD   = 'h10;

    typedef struct packed {
        logic ctrl;
        logic mask;
        logic clr;
    } wr_sel_t;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_CTRL,
        RD_MASK,
        RD_MASKED,
        RD_RAW,
        RD_CARD
    } rd_sel_t;

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_sel_t           wr_sel_o,
    output rd_sel_t           rd_sel_o
);

    always_comb begin
        wr_sel_o = '0;
        rd_sel_o = RD_NONE;
        if (addr_i == ADDR_W'(OFS_CTRL)) begin
            rd_sel_o      = RD_CTRL;
            wr_sel_o.ctrl = wr_i;
        end else if (addr_i == ADDR_W'(OFS_MASK)) begin
            rd_sel_o      = RD_MASK;
            wr_sel_o.mask = wr_i;
        end else if (addr_i == ADDR_W'(OFS_MASKED)) begin
            rd_sel_o     = RD_MASKED;
            wr_sel_o.clr = wr_i;
        end else if (addr_i == ADDR_W'(OFS_RAW)) begin
            rd_sel_o     = RD_RAW;
            wr_sel_o.clr = wr_i;
        end else if (addr_i == ADDR_W'(OFS_CARD)) begin
            rd_sel_o = RD_CARD;
        end
    end

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
    parameter int REG_W   = 32,
    localparam int NUM_EVT = REG_W - 2,
    localparam int INS_BIT = REG_W - 2,
    localparam int REM_BIT = REG_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               card_ins_i,
    input  logic               card_rem_i,
    input  logic               clr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   raw_o,
    output logic               present_o
);

    typedef struct packed {
        logic [REG_W-1:0] raw;
        logic             present;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first, then apply the set sources so they win a collision
        if (clr_i) begin
            st_d.raw = st_d.raw & ~wdata_i;
        end
        st_d.raw = st_d.raw | REG_W'(evt_i);
        if (card_rem_i) begin
            st_d.raw[REM_BIT] = 1'b1;
            st_d.raw[INS_BIT] = 1'b0;
            st_d.present      = 1'b0;
        end else if (card_ins_i) begin
            st_d.raw[INS_BIT] = 1'b1;
            st_d.raw[REM_BIT] = 1'b0;
            st_d.present      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o     = st_q.raw;
    assign present_o = st_q.present;

    assert_evt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw_o[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i)));

    assert_set_beats_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (|(evt_i & wdata_i[NUM_EVT-1:0])))
        |=> ((raw_o[NUM_EVT-1:0] & $past(evt_i & wdata_i[NUM_EVT-1:0])) != '0));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|evt_i) && !card_ins_i && !card_rem_i)
        |=> ((raw_o & $past(wdata_i)) == '0));

    assert_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_ins_i && !card_rem_i) |=> (present_o && raw_o[INS_BIT] && !raw_o[REM_BIT]));

    assert_remove_R7: assert property (@(posedge clk) disable iff (!rst_n)
        card_rem_i |=> (!present_o && raw_o[REM_BIT] && !raw_o[INS_BIT]));

    assert_card_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_o[INS_BIT] && raw_o[REM_BIT]));

endmodule

// File: rtl/evt_irq_cfg.sv
module evt_irq_cfg #(
    parameter int REG_W    = 32,
    parameter int EN_BIT   = 4,
    parameter int RST_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl_i,
    input  logic             wr_mask_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] mask_o,
    output logic             en_o
);

    localparam logic [REG_W-1:0] SELF_CLR = REG_W'((64'd1 << RST_BITS) - 64'd1);

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl_i) begin
            cfg_d.ctrl = wdata_i & ~SELF_CLR;
        end
        if (wr_mask_i) begin
            cfg_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ctrl_o = cfg_q.ctrl;
    assign mask_o = cfg_q.mask;
    assign en_o   = cfg_q.ctrl[EN_BIT];

    assert_ctrl_selfclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl_i |=> ((ctrl_o[RST_BITS-1:0] == '0)
                       && (ctrl_o[REG_W-1:RST_BITS] == $past(wdata_i[REG_W-1:RST_BITS]))));

    assert_mask_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_o == $past(wdata_i)));

endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [REG_W-1:0] raw_i,
    input  logic [REG_W-1:0] mask_i,
    output logic             irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = en_i && (|(raw_i & mask_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i || raw_i != '0 || irq_o) |=> (irq_o == $past(en_i && (|(raw_i & mask_i)))));

    assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> !irq_o);

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int ADDR_W   = 8,
    parameter int EN_BIT   = 4,
    parameter int RST_BITS = 3,
    parameter int PRES_BIT = 8,
    localparam int NUM_EVT = REG_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_set_i,
    input  logic               card_insert_i,
    input  logic               card_remove_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               irq_o
);

    wr_sel_t          wr_sel;
    rd_sel_t          rd_sel;
    logic [REG_W-1:0] raw;
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] mask;
    logic             present;
    logic             irq_en;

    evt_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wr_sel_o (wr_sel),
        .rd_sel_o (rd_sel)
    );

    evt_irq_status #(.REG_W(REG_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_set_i),
        .card_ins_i (card_insert_i),
        .card_rem_i (card_remove_i),
        .clr_i      (wr_sel.clr),
        .wdata_i    (reg_wdata_i),
        .raw_o      (raw),
        .present_o  (present)
    );

    evt_irq_cfg #(.REG_W(REG_W), .EN_BIT(EN_BIT), .RST_BITS(RST_BITS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_sel.ctrl),
        .wr_mask_i (wr_sel.mask),
        .wdata_i   (reg_wdata_i),
        .ctrl_o    (ctrl),
        .mask_o    (mask),
        .en_o      (irq_en)
    );

    evt_irq_out #(.REG_W(REG_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (irq_en),
        .raw_i  (raw),
        .mask_i (mask),
        .irq_o  (irq_o)
    );

    always_comb begin
        case (rd_sel)
            RD_CTRL:   reg_rdata_o = ctrl;
            RD_MASK:   reg_rdata_o = mask;
            RD_MASKED: reg_rdata_o = raw & mask;
            RD_RAW:    reg_rdata_o = raw;
            RD_CARD:   reg_rdata_o = REG_W'(present) << PRES_BIT;
            default:   reg_rdata_o = '0;
        endcase
    end

    assert_masked_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(OFS_MASKED)) |-> (reg_rdata_o == (raw & mask)));

endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] evt_set = '0;
    logic        card_ins = 1'b0;
    logic        card_rem = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    evt_irq_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_set_i     (evt_set),
        .card_insert_i (card_ins),
        .card_remove_i (card_rem),
        .reg_wr_i      (reg_wr),
        .reg_addr_i    (reg_addr),
        .reg_wdata_i   (reg_wdata),
        .reg_rdata_o   (reg_rdata),
        .irq_o         (irq)
    );

    // Monitor: compares queued expectations in the quiet half of the cycle
    always begin
        @(negedge clk);
        #1;
        while (exp_q.size() > 0) begin
            exp_item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = it.is_irq ? {31'd0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [29:0] ev, input bit ins, input bit rem);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        evt_set = ev; card_ins = ins; card_rem = rem;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, '0, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        cyc(1'b0, a, '0, '0, 1'b0, 1'b0);
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic irq_chk(input bit e, input string tag);
        exp_item_t it;
        cyc(1'b0, 8'h00, '0, '0, 1'b0, 1'b0);
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        irq_chk(1'b0, "R1 irq");
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h04, 32'h0, "R1 mask");
        rd(8'h08, 32'h0, "R1 masked");
        rd(8'h0C, 32'h0, "R1 raw");
        rd(8'h10, 32'h0, "R1 card");

        // R2 events stick
        cyc(1'b0, 8'h00, '0, 30'h2000_0008, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, '0, 30'h0000_0001, 1'b0, 1'b0);
        rd(8'h0C, 32'h2000_0009, "R2 raw after pulses");
        rd(8'h0C, 32'h2000_0009, "R2 raw held");

        // R3 / R10 mask and views
        wr(8'h04, 32'h0000_0008);
        rd(8'h04, 32'h0000_0008, "R10 mask readback");
        rd(8'h08, 32'h0000_0008, "R3 masked view");
        rd(8'h0C, 32'h2000_0009, "R3 raw view");

        // R8 / R9 control and interrupt lag
        wr(8'h00, 32'hFFFF_FFFF);
        irq_chk(1'b0, "R9 irq lags enable");
        irq_chk(1'b1, "R9 irq asserted");
        rd(8'h00, 32'hFFFF_FFF8, "R8 ctrl self-clear");
        wr(8'h00, 32'h0000_0007);
        irq_chk(1'b1, "R9 irq lags disable");
        irq_chk(1'b0, "R9 irq off when disabled");
        rd(8'h00, 32'h0, "R8 ctrl low bits");
        wr(8'h00, 32'h0000_0010);
        irq_chk(1'b0, "R9 lag re-enable");
        irq_chk(1'b1, "R9 re-enabled");

        // R4 clear through masked view, then raw view
        wr(8'h08, 32'h0000_0008);
        irq_chk(1'b1, "R9 lag after clear");
        irq_chk(1'b0, "R9 drop after clear");
        rd(8'h0C, 32'h2000_0001, "R4 clear via masked");
        wr(8'h0C, 32'h2000_0000);
        rd(8'h0C, 32'h0000_0001, "R4 clear via raw");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R4 clear all");

        // R5 set beats clear
        cyc(1'b0, 8'h00, '0, 30'h20, 1'b0, 1'b0);
        cyc(1'b1, 8'h0C, 32'h20, 30'h20, 1'b0, 1'b0);
        rd(8'h0C, 32'h20, "R5 same bit");
        cyc(1'b1, 8'h0C, 32'h20, 30'h40, 1'b0, 1'b0);
        rd(8'h0C, 32'h40, "R5 other bit");
        wr(8'h0C, 32'h40);

        // R6 / R7 card detect
        cyc(1'b0, 8'h00, '0, '0, 1'b1, 1'b0);
        rd(8'h0C, 32'h4000_0000, "R6 insert raw");
        rd(8'h10, 32'h0000_0100, "R6 present");
        cyc(1'b0, 8'h00, '0, '0, 1'b0, 1'b1);
        rd(8'h0C, 32'h8000_0000, "R7 remove raw");
        rd(8'h10, 32'h0, "R7 not present");
        cyc(1'b0, 8'h00, '0, '0, 1'b1, 1'b0);
        rd(8'h0C, 32'h4000_0000, "R6 reinsert raw");
        cyc(1'b0, 8'h00, '0, '0, 1'b1, 1'b1);
        rd(8'h0C, 32'h8000_0000, "R7 both remove wins");
        rd(8'h10, 32'h0, "R7 both present");
        cyc(1'b0, 8'h00, '0, '0, 1'b1, 1'b0);
        wr(8'h0C, 32'h4000_0000);
        rd(8'h0C, 32'h0, "R6 clear insert bit");
        rd(8'h10, 32'h0000_0100, "R6 present kept");

        // R9 via card removal bit and mask
        wr(8'h04, 32'h8000_0000);
        cyc(1'b0, 8'h00, '0, '0, 1'b0, 1'b1);
        irq_chk(1'b0, "R9 card lag");
        irq_chk(1'b1, "R9 card irq");

        // R10 ignored writes
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R10 card read-only");
        rd(8'h14, 32'h0, "R10 unmapped reads zero");
        rd(8'h00, 32'h0000_0010, "R10 ctrl untouched");
        rd(8'h04, 32'h8000_0000, "R10 mask untouched");
        rd(8'h0C, 32'h8000_0000, "R10 raw untouched");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule